// File: doc/BRIEF.md
# Watchdog and Interval Timer

An up-counter driven by a selectable prescaler tap that serves one of two roles. As a watchdog, the counter must be rewritten by software before it passes its top value. If it is not, the block drives an active-low overflow strobe for a fixed number of cycles and may also raise a system-reset request. As an interval timer, the same counter wraps freely and each wrap raises a level interrupt.

Software reaches the block through a simple register port with three locations: the count, a control/status word and a reset-control word. Writes carry a key byte in the upper half of the write word. While the overflow strobe is low, the register file is frozen. The overflow flags clear only through a read-then-write-zero handshake. The strobe is an output only. The reset request is a separate output meant for external reset logic and never loops back into this block.

Top module: `wdt_itimer`

## Requirements
- R1: After reset, all three registers read 0x00, `ovf_n` is 1, and `sys_rst_req` and `itv_irq` are 0.
- R2: A write is taken only with the right key in `bus_wdata[15:8]`. The count (address 0) and reset-control (address 2) need 0x5A. Control/status (address 1) needs 0xA5. Any other write changes nothing.
- R3: Control bits [2:0] choose the tick period: 2, 64, 128, 512, 2048, 8192, 32768 or 131072 clocks for codes 0 to 7. While enable (control bit 5) is 1, the count steps once per period. The first step comes one full period after enabling. The prescaler is cleared while the timer is disabled.
- R4: In interval mode (control bit 6 = 0), a step from 0xFF wraps the count to 0x00 and sets the interval flag (control bit 7). `itv_irq` follows that flag.
- R5: In watchdog mode (control bit 6 = 1), a step from 0xFF drives `ovf_n` low for exactly 132 cycles, starting one cycle later. The count and control/status return to 0x00, and the watchdog flag (reset-control bit 7) is set.
- R6: `sys_rst_req` is high for exactly 518 cycles after a watchdog overflow only if reset-enable (reset-control bit 6) was 1 at that overflow. Otherwise it stays 0.
- R7: A write to control/status changes the mode bit only if enable is 0 before that write.
- R8: While `ovf_n` is low, every register write is ignored.
- R9: A flag clears only if software reads its register while the flag is set and `ovf_n` is high, then writes that bit as 0. A zero write with no such read leaves the flag set, and a read made while `ovf_n` is low does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 count, 1 control/status, 2 reset-control |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (used for flag-clear arming) |
| bus_wdata | input | 16 | Key byte [15:8], data byte [7:0] |
| bus_rdata | output | 8 | Contents of the selected register |
| ovf_n | output | 1 | Active-low watchdog overflow strobe |
| sys_rst_req | output | 1 | System reset request |
| itv_irq | output | 1 | Interval-timer interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit count, strobe lengths of 132 and 518 cycles, and the full 17-bit prescaler. It can therefore measure the exact pulse widths and lock windows the requirements name. The fast taps (divide by 2 and 64) make full watchdog and interval overflows cheap to reach. The divide-by-8192 tap is also run to a first step. A cycle-accurate behavioural model checks every output and the selected register on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic {MODE_ITV = 1'b0, MODE_WD = 1'b1} wdt_mode_e;

   localparam int NUM_TAPS  = 8;
   localparam int SEL_W     = 3;
   localparam logic [1:0] ADDR_CNT  = 2'd0;
   localparam logic [1:0] ADDR_CTL  = 2'd1;
   localparam logic [1:0] ADDR_RCTL = 2'd2;

   localparam int CTL_EN   = 5;
   localparam int CTL_MODE = 6;
   localparam int CTL_IFLG = 7;
   localparam int RC_REN   = 6;
   localparam int RC_WFLG  = 7;

   // log2 of the prescaler division for each select code
   function automatic int tap_log2(input int code);
      case (code)
         0: return 1;
         1: return 6;
         2: return 7;
         3: return 9;
         4: return 11;
         5: return 13;
         6: return 15;
         default: return 17;
      endcase
   endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int PRE_W = 17
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic [wdt_pkg::SEL_W-1:0] sel,
   output logic                     tick
);
   import wdt_pkg::*;

   if (PRE_W < tap_log2(NUM_TAPS - 1)) begin : g_bad_w
      initial $fatal(1, "wdt_prescaler: PRE_W too small for widest tap");
   end

   logic [PRE_W-1:0]    pre_q;
   logic [NUM_TAPS-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pre_q <= '0;
      else if (en) pre_q <= pre_q + 1'b1;
      else         pre_q <= '0;
   end

   for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
      localparam int K = tap_log2(i);
      assign hit[i] = &pre_q[K-1:0];
   end

   assign tick = en & hit[sel];

   p_idle_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (pre_q == '0));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
   parameter int LEN = 132
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   localparam int CW = $clog2(LEN + 1);

   if (LEN < 1) begin : g_bad_len
      initial $fatal(1, "wdt_pulse: LEN must be positive");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (start)        cnt_q <= CW'(LEN);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign active = (cnt_q != '0);

   p_start_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> active);
   p_hold_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q > CW'(1)) |=> active);
endmodule

// File: rtl/wdt_itimer.sv
module wdt_itimer #(
   parameter int              CNT_W    = 8,
   parameter int              PRE_W    = 17,
   parameter int              OVF_LEN  = 132,
   parameter int              RST_LEN  = 518,
   parameter logic [CNT_W-1:0] KEY_CNT = 'h5A,
   parameter logic [CNT_W-1:0] KEY_CTL = 'hA5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [2*CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0]   bus_rdata,
   output logic               ovf_n,
   output logic               sys_rst_req,
   output logic               itv_irq
);
   import wdt_pkg::*;

   if (CNT_W < 8) begin : g_bad_cnt
      initial $fatal(1, "wdt_itimer: CNT_W must be at least 8");
   end

   logic [CNT_W-1:0] key, dat;
   logic [CNT_W-1:0] cnt_q;
   logic [SEL_W-1:0] sel_q;
   logic             en_q, iflg_q, arm_i_q, ren_q, wflg_q, arm_w_q;
   wdt_mode_e        mode_q;
   logic             tick, lock, ovf_act;
   logic             wr_cnt, wr_ctl, wr_rc, rd_ok;
   logic             wd_ovf, itv_ovf, at_top;

   assign key    = bus_wdata[2*CNT_W-1:CNT_W];
   assign dat    = bus_wdata[CNT_W-1:0];
   assign lock   = ovf_act;
   assign rd_ok  = bus_rd & ~lock;
   assign wr_cnt = bus_wr & ~lock & (bus_addr == ADDR_CNT)  & (key == KEY_CNT);
   assign wr_ctl = bus_wr & ~lock & (bus_addr == ADDR_CTL)  & (key == KEY_CTL);
   assign wr_rc  = bus_wr & ~lock & (bus_addr == ADDR_RCTL) & (key == KEY_CNT);
   assign at_top  = (cnt_q == '1);
   assign wd_ovf  = tick & at_top & (mode_q == MODE_WD);
   assign itv_ovf = tick & at_top & (mode_q == MODE_ITV);

   wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(en_q), .sel(sel_q), .tick(tick));

   wdt_pulse #(.LEN(OVF_LEN)) u_ovf (
      .clk(clk), .rst_n(rst_n), .start(wd_ovf), .active(ovf_act));

   wdt_pulse #(.LEN(RST_LEN)) u_rst (
      .clk(clk), .rst_n(rst_n), .start(wd_ovf & ren_q), .active(sys_rst_req));

   // counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (wd_ovf) cnt_q <= '0;
      else if (wr_cnt) cnt_q <= dat;
      else if (tick)   cnt_q <= cnt_q + 1'b1;
   end

   // control/status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         en_q   <= 1'b0;
         mode_q <= MODE_ITV;
      end else if (wd_ovf) begin
         sel_q  <= '0;
         en_q   <= 1'b0;
         mode_q <= MODE_ITV;
      end else if (wr_ctl) begin
         sel_q <= dat[SEL_W-1:0];
         en_q  <= dat[CTL_EN];
         if (!en_q) mode_q <= wdt_mode_e'(dat[CTL_MODE]);
      end
   end

   // interval flag and its clear handshake
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iflg_q  <= 1'b0;
         arm_i_q <= 1'b0;
      end else if (wd_ovf) begin
         iflg_q  <= 1'b0;
         arm_i_q <= 1'b0;
      end else if (itv_ovf) begin
         iflg_q  <= 1'b1;
         arm_i_q <= 1'b0;
      end else if (wr_ctl && !dat[CTL_IFLG] && arm_i_q) begin
         iflg_q  <= 1'b0;
         arm_i_q <= 1'b0;
      end else if (rd_ok && bus_addr == ADDR_CTL && iflg_q) begin
         arm_i_q <= 1'b1;
      end
   end

   // reset-control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ren_q   <= 1'b0;
         wflg_q  <= 1'b0;
         arm_w_q <= 1'b0;
      end else begin
         if (wr_rc) ren_q <= dat[RC_REN];
         if (wd_ovf) begin
            wflg_q  <= 1'b1;
            arm_w_q <= 1'b0;
         end else if (wr_rc && !dat[RC_WFLG] && arm_w_q) begin
            wflg_q  <= 1'b0;
            arm_w_q <= 1'b0;
         end else if (rd_ok && bus_addr == ADDR_RCTL && wflg_q) begin
            arm_w_q <= 1'b1;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_CNT: bus_rdata = cnt_q;
         ADDR_CTL: begin
            bus_rdata[SEL_W-1:0] = sel_q;
            bus_rdata[CTL_EN]    = en_q;
            bus_rdata[CTL_MODE]  = mode_q;
            bus_rdata[CTL_IFLG]  = iflg_q;
         end
         ADDR_RCTL: begin
            bus_rdata[RC_REN]  = ren_q;
            bus_rdata[RC_WFLG] = wflg_q;
         end
         default: bus_rdata = '0;
      endcase
   end

   assign ovf_n   = ~ovf_act;
   assign itv_irq = iflg_q;

   p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_n |=> ($stable(cnt_q) && $stable(sel_q) && $stable(ren_q)));
   p_mode_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !wd_ovf) |=> (mode_q == $past(mode_q)));
   p_wd_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wd_ovf |=> (cnt_q == '0 && !en_q && !ovf_n && wflg_q));
   p_irq_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      itv_ovf |=> (itv_irq && cnt_q == '0));
   p_wflag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wflg_q) |-> ($past(arm_w_q) && $past(ovf_n)));
   p_rst_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_ovf && !ren_q && !sys_rst_req) |=> !sys_rst_req);
endmodule

// File: tb/wdt_itimer_test.sv
module wdt_itimer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0] bus_wdata = 16'h0;
   logic [7:0]  bus_rdata;
   logic        ovf_n, sys_rst_req, itv_irq;

   int total = 0, bad = 0, cyc = 0;

   always #10 clk = ~clk;

   wdt_itimer uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ovf_n(ovf_n), .sys_rst_req(sys_rst_req), .itv_irq(itv_irq));

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int divof(input int s);
      case (s)
         0: return 2;       1: return 64;     2: return 128;   3: return 512;
         4: return 2048;    5: return 8192;   6: return 32768; default: return 131072;
      endcase
   endfunction

   // behavioural reference model
   int m_cnt, m_sel, m_en, m_mode, m_if, m_ai, m_ren, m_wf, m_aw, m_pre, m_oc, m_rc;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_sel = 0; m_en = 0; m_mode = 0; m_if = 0; m_ai = 0;
         m_ren = 0; m_wf = 0; m_aw = 0; m_pre = 0; m_oc = 0; m_rc = 0;
      end else begin
         int  k, d, n_cnt, n_sel, n_en, n_mode, n_if, n_ai, n_wf, n_aw;
         bit  lk, tk, wdo, ido, wc, wt, wrc, rok;
         lk  = (m_oc != 0);
         tk  = (m_en != 0) && ((m_pre % divof(m_sel)) == divof(m_sel) - 1);
         wdo = tk && m_cnt == 255 && m_mode == 1;
         ido = tk && m_cnt == 255 && m_mode == 0;
         k = bus_wdata[15:8]; d = bus_wdata[7:0];
         wc  = bus_wr && !lk && bus_addr == 0 && k == 'h5A;
         wt  = bus_wr && !lk && bus_addr == 1 && k == 'hA5;
         wrc = bus_wr && !lk && bus_addr == 2 && k == 'h5A;
         rok = bus_rd && !lk;
         n_cnt = wdo ? 0 : wc ? d : tk ? (m_cnt + 1) % 256 : m_cnt;
         n_sel = m_sel; n_en = m_en; n_mode = m_mode;
         if (wdo) begin n_sel = 0; n_en = 0; n_mode = 0; end
         else if (wt) begin
            n_sel = d % 8; n_en = (d >> 5) & 1;
            if (m_en == 0) n_mode = (d >> 6) & 1;
         end
         n_if = m_if; n_ai = m_ai;
         if (wdo) begin n_if = 0; n_ai = 0; end
         else if (ido) begin n_if = 1; n_ai = 0; end
         else if (wt && ((d >> 7) & 1) == 0 && m_ai) begin n_if = 0; n_ai = 0; end
         else if (rok && bus_addr == 1 && m_if) n_ai = 1;
         n_wf = m_wf; n_aw = m_aw;
         if (wdo) begin n_wf = 1; n_aw = 0; end
         else if (wrc && ((d >> 7) & 1) == 0 && m_aw) begin n_wf = 0; n_aw = 0; end
         else if (rok && bus_addr == 2 && m_wf) n_aw = 1;
         m_rc  = (wdo && m_ren) ? 518 : (m_rc > 0 ? m_rc - 1 : 0);
         m_oc  = wdo ? 132 : (m_oc > 0 ? m_oc - 1 : 0);
         if (wrc) m_ren = (d >> 6) & 1;
         m_pre = m_en ? (m_pre + 1) % 131072 : 0;
         m_cnt = n_cnt; m_sel = n_sel; m_en = n_en; m_mode = n_mode;
         m_if = n_if; m_ai = n_ai; m_wf = n_wf; m_aw = n_aw;
         #5;
         begin
            int exp_rd;
            case (bus_addr)
               2'd0: exp_rd = m_cnt;
               2'd1: exp_rd = m_sel | (m_en << 5) | (m_mode << 6) | (m_if << 7);
               2'd2: exp_rd = (m_ren << 6) | (m_wf << 7);
               default: exp_rd = 0;
            endcase
            check("R3 rdata vs model", bus_rdata, exp_rd);
            check("R5 ovf_n vs model", ovf_n, m_oc == 0);
            check("R6 sys_rst_req vs model", sys_rst_req, m_rc != 0);
            check("R4 itv_irq vs model", itv_irq, m_if);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] k, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = {k, d}; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output int v);
      @(negedge clk); bus_addr = a; #1 v = bus_rdata;
   endtask

   task automatic wait_low();
      int g = 0;
      @(posedge clk); #5;
      while (ovf_n !== 1'b0 && g < 3000) begin @(posedge clk); #5; g++; end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk); cyc++;
         if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            finish_run();
         end
      end
   end

   initial begin
      int v, n_o, n_r, g;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      peek(0, v); check("R1 count", v, 0);
      peek(1, v); check("R1 ctl", v, 0);
      peek(2, v); check("R1 rctl", v, 0);
      check("R1 ovf_n", ovf_n, 1);
      check("R1 sys_rst_req", sys_rst_req, 0);
      check("R1 itv_irq", itv_irq, 0);
      // R2 keys
      wr(0, 8'h00, 8'h33); peek(0, v); check("R2 bad count key", v, 0);
      wr(0, 8'h5A, 8'h33); peek(0, v); check("R2 good count key", v, 'h33);
      wr(1, 8'h5A, 8'h21); peek(1, v); check("R2 bad ctl key", v, 0);
      wr(2, 8'hA5, 8'h40); peek(2, v); check("R2 bad rctl key", v, 0);
      // R3 divide by 64
      wr(0, 8'h5A, 8'h00); wr(1, 8'hA5, 8'h21);
      repeat (200) @(negedge clk);
      peek(0, v); check("R3 div64 steps", v, 3);
      wr(1, 8'hA5, 8'h01); peek(0, v);
      repeat (100) @(negedge clk);
      begin int v2; peek(0, v2); check("R3 hold when disabled", v2, v); end
      // R3 divide by 8192
      wr(0, 8'h5A, 8'h00); wr(1, 8'hA5, 8'h25);
      repeat (8100) @(negedge clk);
      peek(0, v); check("R3 div8192 before period", v, 0);
      repeat (200) @(negedge clk);
      peek(0, v); check("R3 div8192 after period", v, 1);
      // R4 interval wrap
      wr(1, 8'hA5, 8'h00); wr(0, 8'h5A, 8'hFE); wr(1, 8'hA5, 8'h20);
      repeat (10) @(negedge clk);
      check("R4 irq raised", itv_irq, 1);
      peek(1, v); check("R4 flag bit", (v >> 7) & 1, 1);
      // R9 interval flag handshake
      wr(1, 8'hA5, 8'h20); check("R9 zero write without read", itv_irq, 1);
      rd(1); wr(1, 8'hA5, 8'h20); check("R9 read then zero clears", itv_irq, 0);
      // R7 mode change while running
      wr(1, 8'hA5, 8'h60); peek(1, v); check("R7 mode held while enabled", (v >> 6) & 1, 0);
      wr(1, 8'hA5, 8'h00); wr(1, 8'hA5, 8'h40);
      peek(1, v); check("R7 mode taken while disabled", (v >> 6) & 1, 1);
      // R5 R6 watchdog overflow with reset enabled
      wr(2, 8'h5A, 8'h40); wr(0, 8'h5A, 8'hFD); wr(1, 8'hA5, 8'h60);
      wait_low();
      n_o = 0; n_r = 0; g = 0;
      while ((ovf_n == 1'b0 || sys_rst_req == 1'b1) && g < 2000) begin
         if (!ovf_n) n_o++;
         if (sys_rst_req) n_r++;
         @(posedge clk); #5; g++;
      end
      check("R5 strobe length", n_o, 132);
      check("R6 reset request length", n_r, 518);
      peek(0, v); check("R5 count returned", v, 0);
      peek(1, v); check("R5 ctl returned", v, 0);
      peek(2, v); check("R5 flag set", v, 'hC0);
      // R9 zero write without read; R6 reset disabled
      wr(2, 8'h5A, 8'h00); peek(2, v); check("R9 flag kept without read", v, 'h80);
      wr(0, 8'h5A, 8'hFE); wr(1, 8'hA5, 8'h60);
      wait_low();
      check("R6 no request when disabled", sys_rst_req, 0);
      // R8 writes during strobe
      wr(0, 8'h5A, 8'h77); wr(1, 8'hA5, 8'h21); wr(2, 8'h5A, 8'h40);
      rd(2);
      n_r = 0;
      while (ovf_n == 1'b0) begin
         if (sys_rst_req) n_r++;
         @(posedge clk); #5;
      end
      check("R6 stayed low", n_r, 0);
      peek(0, v); check("R8 count write ignored", v, 0);
      peek(1, v); check("R8 ctl write ignored", v, 0);
      wr(2, 8'h5A, 8'h00); peek(2, v); check("R9 locked read not armed", v, 'h80);
      rd(2); wr(2, 8'h5A, 8'h00); peek(2, v); check("R9 flag cleared", v, 0);
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule